// File: doc/BRIEF.md
# One-Time Fuse Array Controller

This block fronts a small one-time-programmable fuse array and keeps a shadow copy of every fuse word that software can read at any time over a simple register port. Three operations are available: a direct read of one fuse word, a keyed program of one fuse word, and a reload that refreshes every shadow word from the array. Only one operation runs at a time. A request made while an operation is in flight is refused and flagged in a sticky error bit.

Every operation goes through a sequencer. It first counts out a wait phase and then a strobe phase. The strobe phase frames an active fuse pulse between two relax intervals. All of these lengths are cycle counts held in a timing register, so software can set them from the clock frequency. The usual targets are wait at least 150 ns, relax at least 100 ns, read strobe at least 40 ns, and program pulse near 10 µs. The fuse array itself is a behavioural register array. Programming can only turn bits from 0 to 1.

Register offsets on `reg_addr`: 0 control, 1 control set alias, 2 control clear alias, 3 timing, 4 program data, 5 read command, 6 read result, 16 + i shadow word i.

Top module: `fuse_ctrl`

## Requirements
- R1: The control word reads the same at offsets 0, 1 and 2. Its layout is: word address in bits [3:0], busy in bit 8, error in bit 9, reload in bit 10, unlock key in bits [31:16]. A write to offset 0 replaces the address and the key. A write to offset 1 ORs into them. A write to offset 2 clears the bits written as 1.
- R2: After reset, the control word, timing, program data, read result and every shadow word read as zero.
- R3: Writing 1 to bit 0 at offset 5 starts a direct read of the word at the control address. When the read completes, offset 6 holds that fuse word.
- R4: With 0x3E77 in the key field, a write to offset 4 programs the addressed fuse word with (old OR data). The shadow word does not change until a reload is run.
- R5: A write to offset 4 with any other key sets the error bit and leaves every fuse unchanged. Every write to offset 4 returns the key field to zero.
- R6: Writing 1 to control bit 10 through offset 0 or 1 copies every fuse word into its shadow. Bit 10 reads 1 until the last word has been copied and 0 afterwards.
- R7: Busy is high for exactly (W+1)+(S+1) cycles for a read (S = read strobe) or a program (S = program strobe), and for NWORDS·(W+1+Sr+1) cycles for a reload. It is low otherwise.
- R8: `fuse_pulse` goes high R+1 cycles into the strobe phase and lasts (S+1)−2·(R+1) cycles. It stays low when that value is zero or less.
- R9: A read start, a program write, a reload request or a timing write that arrives while busy is refused (no state change) and sets the error bit.
- R10: The error bit stays set until 1 is written to bit 9 at offset 2. A write to offset 0 does not clear it.
- R11: The timing register at offset 3 holds the program strobe in [11:0], relax in [15:12], the read strobe in [21:16] and wait in [27:22]. Bits [31:28] read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the offset sampled on the previous clock |
| fuse_pulse | output | 1 | Active fuse strobe pulse |

## Verification
A wrong internal phase counter shows up at the ports within one cycle. It moves `fuse_pulse` and the busy bit away from the cycle the reference model predicts. A corrupted fuse or shadow word stays hidden until it is read back through offset 6 or the shadow window, so the bench reads after every program and reload. A wrong key register or a wrong error bit shows in the control word on the next read, which the bench polls continuously while operations run.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int unsigned DW         = 32;
  localparam int unsigned KEY_W      = 16;
  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

  // register offsets
  localparam int unsigned OFS_CTRL  = 0;
  localparam int unsigned OFS_SET   = 1;
  localparam int unsigned OFS_CLR   = 2;
  localparam int unsigned OFS_TIME  = 3;
  localparam int unsigned OFS_DATA  = 4;
  localparam int unsigned OFS_RDCMD = 5;
  localparam int unsigned OFS_RDRES = 6;

  // control word bits
  localparam int unsigned CB_BUSY   = 8;
  localparam int unsigned CB_ERR    = 9;
  localparam int unsigned CB_RELOAD = 10;
  localparam int unsigned KEY_LSB   = 16;

  // timing fields
  localparam int unsigned T_PROG_LSB  = 0;
  localparam int unsigned T_PROG_W    = 12;
  localparam int unsigned T_RELAX_LSB = 12;
  localparam int unsigned T_RELAX_W   = 4;
  localparam int unsigned T_READ_LSB  = 16;
  localparam int unsigned T_READ_W    = 6;
  localparam int unsigned T_WAIT_LSB  = 22;
  localparam int unsigned T_WAIT_W    = 6;
  localparam int unsigned T_USED      = T_WAIT_LSB + T_WAIT_W;
  localparam int unsigned CNT_W       = T_PROG_W;

  typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_PROG, OP_RELOAD} op_e;
endpackage

// File: rtl/fuse_seq.sv
module fuse_seq #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             again,
  input  logic [CNT_W-1:0] wait_cyc,
  input  logic [CNT_W-1:0] relax_cyc,
  input  logic [CNT_W-1:0] strobe_cyc,
  output logic             done,
  output logic             pulse
);
  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_STROBE} phase_e;
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_WAIT;
          cnt_q   <= '0;
        end
        PH_WAIT: if (cnt_q == wait_cyc) begin
          phase_q <= PH_STROBE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        PH_STROBE: if (cnt_q == strobe_cyc) begin
          phase_q <= again ? PH_WAIT : PH_IDLE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign done  = (phase_q == PH_STROBE) && (cnt_q == strobe_cyc);
  // active window sits between a leading and a trailing relax interval
  assign pulse = (phase_q == PH_STROBE) && (cnt_q > relax_cyc) &&
                 (({1'b0, cnt_q} + {1'b0, relax_cyc}) < {1'b0, strobe_cyc});
endmodule

// File: rtl/fuse_store.sv
module fuse_store #(
  parameter int unsigned NWORDS = 16,
  parameter int unsigned DW     = 32,
  localparam int unsigned AW    = $clog2(NWORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] op_sel,
  input  logic          prog_en,
  input  logic [DW-1:0] prog_data,
  input  logic          shadow_en,
  input  logic [AW-1:0] bus_sel,
  output logic [DW-1:0] fuse_word,
  output logic [DW-1:0] shadow_word
);
  logic [DW-1:0] fuse_q   [NWORDS];
  logic [DW-1:0] shadow_q [NWORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NWORDS; i++) begin
        fuse_q[i]   <= '0;
        shadow_q[i] <= '0;
      end
    end else begin
      if (prog_en)   fuse_q[op_sel]   <= fuse_q[op_sel] | prog_data;
      if (shadow_en) shadow_q[op_sel] <= fuse_q[op_sel];
    end
  end

  assign fuse_word   = fuse_q[op_sel];
  assign shadow_word = shadow_q[bus_sel];
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_pkg::*;
#(
  parameter int unsigned NWORDS = 16,
  localparam int unsigned AW     = $clog2(NWORDS),
  localparam int unsigned REG_AW = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              fuse_pulse
);
  localparam logic [DW-1:0] T_MASK = DW'((64'd1 << T_USED) - 1);

  op_e              op_q;
  logic [AW-1:0]    word_addr_q, op_addr_q, idx_q;
  logic [KEY_W-1:0] unlock_q;
  logic             err_q;
  logic [DW-1:0]    timing_q, data_q, rd_res_q;

  logic busy, reload_bit, done, again;
  logic wr_ctrl, wr_set, wr_clr, wr_time, wr_data, wr_rdcmd;
  logic req_reload, req_read, bad_req, go_read, go_prog, go_reload;
  logic [CNT_W-1:0] wait_c, relax_c, strobe_c;
  logic [AW-1:0]    store_sel;
  logic [DW-1:0]    fuse_word, shadow_word, ctrl_view, rd_mux;

  assign busy       = (op_q != OP_IDLE);
  assign reload_bit = (op_q == OP_RELOAD);

  assign wr_ctrl  = reg_we && (reg_addr == REG_AW'(OFS_CTRL));
  assign wr_set   = reg_we && (reg_addr == REG_AW'(OFS_SET));
  assign wr_clr   = reg_we && (reg_addr == REG_AW'(OFS_CLR));
  assign wr_time  = reg_we && (reg_addr == REG_AW'(OFS_TIME));
  assign wr_data  = reg_we && (reg_addr == REG_AW'(OFS_DATA));
  assign wr_rdcmd = reg_we && (reg_addr == REG_AW'(OFS_RDCMD));

  assign req_reload = (wr_ctrl || wr_set) && reg_wdata[CB_RELOAD];
  assign req_read   = wr_rdcmd && reg_wdata[0];
  assign go_read    = !busy && req_read;
  assign go_prog    = !busy && wr_data && (unlock_q == UNLOCK_KEY);
  assign go_reload  = !busy && req_reload;
  assign bad_req    = (busy && (req_reload || req_read || wr_data || wr_time)) ||
                      (!busy && wr_data && (unlock_q != UNLOCK_KEY));

  assign wait_c   = CNT_W'(timing_q[T_WAIT_LSB  +: T_WAIT_W]);
  assign relax_c  = CNT_W'(timing_q[T_RELAX_LSB +: T_RELAX_W]);
  assign strobe_c = (op_q == OP_PROG) ? CNT_W'(timing_q[T_PROG_LSB +: T_PROG_W])
                                      : CNT_W'(timing_q[T_READ_LSB +: T_READ_W]);
  assign again     = reload_bit && (idx_q != AW'(NWORDS - 1));
  assign store_sel = reload_bit ? idx_q : op_addr_q;

  fuse_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (go_read || go_prog || go_reload),
    .again      (again),
    .wait_cyc   (wait_c),
    .relax_cyc  (relax_c),
    .strobe_cyc (strobe_c),
    .done       (done),
    .pulse      (fuse_pulse)
  );

  fuse_store #(.NWORDS(NWORDS), .DW(DW)) u_store (
    .clk         (clk),
    .rst         (rst),
    .op_sel      (store_sel),
    .prog_en     (done && (op_q == OP_PROG)),
    .prog_data   (data_q),
    .shadow_en   (done && reload_bit),
    .bus_sel     (reg_addr[AW-1:0]),
    .fuse_word   (fuse_word),
    .shadow_word (shadow_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q        <= OP_IDLE;
      word_addr_q <= '0;
      op_addr_q   <= '0;
      idx_q       <= '0;
      unlock_q    <= '0;
      err_q       <= 1'b0;
      timing_q    <= '0;
      data_q      <= '0;
      rd_res_q    <= '0;
    end else begin
      if (done) begin
        unique case (op_q)
          OP_READ: begin
            rd_res_q <= fuse_word;
            op_q     <= OP_IDLE;
          end
          OP_RELOAD: if (again) idx_q <= idx_q + 1'b1;
                     else op_q <= OP_IDLE;
          default: op_q <= OP_IDLE;
        endcase
      end
      if (go_read) begin
        op_q      <= OP_READ;
        op_addr_q <= word_addr_q;
      end
      if (go_prog) begin
        op_q      <= OP_PROG;
        op_addr_q <= word_addr_q;
        data_q    <= reg_wdata;
      end
      if (go_reload) begin
        op_q  <= OP_RELOAD;
        idx_q <= '0;
      end
      if (wr_ctrl) begin
        word_addr_q <= reg_wdata[AW-1:0];
        unlock_q    <= reg_wdata[KEY_LSB +: KEY_W];
      end
      if (wr_set) begin
        word_addr_q <= word_addr_q | reg_wdata[AW-1:0];
        unlock_q    <= unlock_q | reg_wdata[KEY_LSB +: KEY_W];
      end
      if (wr_clr) begin
        word_addr_q <= word_addr_q & ~reg_wdata[AW-1:0];
        unlock_q    <= unlock_q & ~reg_wdata[KEY_LSB +: KEY_W];
        if (reg_wdata[CB_ERR]) err_q <= 1'b0;
      end
      if (wr_data) unlock_q <= '0;
      if (wr_time && !busy) timing_q <= reg_wdata & T_MASK;
      if (bad_req) err_q <= 1'b1;
      reg_rdata <= rd_mux;
    end
  end

  always_comb begin
    ctrl_view                       = '0;
    ctrl_view[AW-1:0]               = word_addr_q;
    ctrl_view[CB_BUSY]              = busy;
    ctrl_view[CB_ERR]               = err_q;
    ctrl_view[CB_RELOAD]            = reload_bit;
    ctrl_view[KEY_LSB +: KEY_W]     = unlock_q;
    rd_mux = '0;
    if (reg_addr[REG_AW-1]) rd_mux = shadow_word;
    else if (reg_addr == REG_AW'(OFS_CTRL) || reg_addr == REG_AW'(OFS_SET) ||
             reg_addr == REG_AW'(OFS_CLR))    rd_mux = ctrl_view;
    else if (reg_addr == REG_AW'(OFS_TIME))  rd_mux = timing_q;
    else if (reg_addr == REG_AW'(OFS_DATA))  rd_mux = data_q;
    else if (reg_addr == REG_AW'(OFS_RDRES)) rd_mux = rd_res_q;
  end
endmodule

// File: rtl/fuse_ctrl_chk.sv
module fuse_ctrl_chk #(
  parameter int unsigned REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic              wd_go,
  input logic              wd_err,
  input logic              fuse_pulse,
  input logic              busy,
  input logic              err_q,
  input logic [15:0]       unlock_q
);
  assert_pulse_in_op_R8: assert property (@(posedge clk) disable iff (rst)
    fuse_pulse |-> busy);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(reg_we && reg_addr == REG_AW'(2) && wd_err)) |=> err_q);

  assert_key_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == REG_AW'(4)) |=> (unlock_q == 16'h0));

  assert_overlap_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_we && reg_addr == REG_AW'(5) && wd_go) |=> err_q);

  assert_start_by_write_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_we));
endmodule

bind fuse_ctrl fuse_ctrl_chk #(.REG_AW(REG_AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .wd_go      (reg_wdata[0]),
  .wd_err     (reg_wdata[9]),
  .fuse_pulse (fuse_pulse),
  .busy       (busy),
  .err_q      (err_q),
  .unlock_q   (unlock_q)
);

// File: tb/sim_fuse_ctrl.sv
`timescale 1ns/1ps
module sim_fuse_ctrl;
  localparam int N = 16;
  localparam logic [31:0] KEYW = 32'h3E77_0000;
  localparam logic [31:0] T0 = 32'h0085_1009; // W2 R1 Sr5 Sp9
  localparam logic [31:0] T1 = 32'h0085_3009; // relax 3, no read pulse

  logic clk = 1'b0, rst = 1'b1, reg_we = 1'b0, fuse_pulse;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int total = 0, bad = 0, cycles = 0;

  always #2.5 clk = ~clk;

  fuse_ctrl u0 (.clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
                .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fuse_pulse(fuse_pulse));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_op, m_t, m_idx, m_a;
  logic [31:0] m_fuse [N];
  logic [31:0] m_shadow [N];
  logic [31:0] m_timing, m_data, m_rd, exp_rdata;
  logic [3:0] m_addr;
  logic [15:0] m_unlock;
  logic m_err, exp_pulse, m_valid;
  logic [4:0] last_addr;

  function automatic int f_w();  return int'(m_timing[27:22]); endfunction
  function automatic int f_r();  return int'(m_timing[15:12]); endfunction
  function automatic int f_s();  return (m_op == 2) ? int'(m_timing[11:0]) : int'(m_timing[21:16]); endfunction

  function automatic logic [31:0] m_view(input logic [4:0] a);
    logic [31:0] c;
    c = {m_unlock, 5'b0, m_op == 3, m_err, m_op != 0, 4'b0, m_addr};
    if (a[4]) return m_shadow[a[3:0]];
    case (a)
      5'd0, 5'd1, 5'd2: return c;
      5'd3: return m_timing;
      5'd4: return m_data;
      5'd6: return m_rd;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_op = 0; m_t = 0; m_idx = 0; m_a = 0;
      for (int i = 0; i < N; i++) begin m_fuse[i] = 0; m_shadow[i] = 0; end
      m_timing = 0; m_data = 0; m_rd = 0; m_addr = 0; m_unlock = 0; m_err = 0;
      exp_rdata = 0; exp_pulse = 0; m_valid = 0;
    end else begin
      automatic bit busy_pre = (m_op != 0);
      exp_rdata = m_view(reg_addr);
      last_addr = reg_addr;
      if (m_op != 0) begin
        if (m_t == f_w() + f_s() + 1) begin
          m_t = 0;
          if (m_op == 1) begin m_rd = m_fuse[m_a]; m_op = 0; end
          else if (m_op == 2) begin m_fuse[m_a] = m_fuse[m_a] | m_data; m_op = 0; end
          else begin
            m_shadow[m_idx] = m_fuse[m_idx];
            if (m_idx == N - 1) m_op = 0; else m_idx++;
          end
        end else m_t++;
      end
      if (reg_we) begin
        case (reg_addr)
          5'd0, 5'd1: begin
            if (reg_addr == 0) begin m_addr = reg_wdata[3:0]; m_unlock = reg_wdata[31:16]; end
            else begin m_addr |= reg_wdata[3:0]; m_unlock |= reg_wdata[31:16]; end
            if (reg_wdata[10]) begin
              if (busy_pre) m_err = 1; else begin m_op = 3; m_idx = 0; m_t = 0; end
            end
          end
          5'd2: begin
            m_addr &= ~reg_wdata[3:0]; m_unlock &= ~reg_wdata[31:16];
            if (reg_wdata[9]) m_err = 0;
          end
          5'd3: if (busy_pre) m_err = 1; else m_timing = reg_wdata & 32'h0FFF_FFFF;
          5'd4: begin
            if (busy_pre || m_unlock != 16'h3E77) m_err = 1;
            else begin m_op = 2; m_t = 0; m_a = m_addr; m_data = reg_wdata; end
            m_unlock = 0;
          end
          5'd5: if (reg_wdata[0]) begin
            if (busy_pre) m_err = 1; else begin m_op = 1; m_t = 0; m_a = m_addr; end
          end
          default: ;
        endcase
      end
      exp_pulse = 0;
      if (m_op != 0) begin
        automatic int k = m_t - (f_w() + 1);
        exp_pulse = (k >= f_r() + 1) && (k <= f_s() - f_r() - 1);
      end
      m_valid = 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && m_valid) begin
      string tg;
      if (last_addr[4]) tg = "R6";
      else if (last_addr <= 2) tg = "R1";
      else if (last_addr == 3) tg = "R11";
      else if (last_addr == 4) tg = "R4";
      else tg = "R3";
      chk(reg_rdata === exp_rdata, tg, reg_rdata, exp_rdata);
      chk(fuse_pulse === exp_pulse, "R8", {31'b0, fuse_pulse}, {31'b0, exp_pulse});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic poll(output int nb, output int np);
    nb = 0; np = 0; reg_addr = 5'd0;
    for (int g = 0; g < 5000; g++) begin
      @(posedge clk); @(negedge clk);
      if (fuse_pulse) np++;
      if (reg_rdata[8]) nb++; else break;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int nb, np;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: reset state
    rd(5'd0, v);  chk(v == 0, "R2 ctrl", v, 0);
    rd(5'd3, v);  chk(v == 0, "R2 timing", v, 0);
    rd(5'd6, v);  chk(v == 0, "R2 result", v, 0);
    rd(5'd21, v); chk(v == 0, "R2 shadow", v, 0);
    // R11: timing layout
    wr(5'd3, 32'hFFFF_FFFF); rd(5'd3, v); chk(v == 32'h0FFF_FFFF, "R11 mask", v, 32'h0FFF_FFFF);
    wr(5'd3, T0); rd(5'd3, v); chk(v == T0, "R11 fields", v, T0);
    // R1: aliases
    wr(5'd1, KEYW | 32'h3); rd(5'd0, v); chk(v == 32'h3E77_0003, "R1 set", v, 32'h3E77_0003);
    wr(5'd2, 32'h1);        rd(5'd1, v); chk(v == 32'h3E77_0002, "R1 clr", v, 32'h3E77_0002);
    wr(5'd0, 32'h5);        rd(5'd2, v); chk(v == 32'h0000_0005, "R1 base", v, 32'h5);
    // R4/R7/R8: program
    wr(5'd1, KEYW); wr(5'd4, 32'h0000_00F0); poll(nb, np);
    chk(nb == 13, "R7 prog busy", nb, 13);
    chk(np == 6, "R8 prog pulse", np, 6);
    rd(5'd0, v); chk(v == 32'h5, "R5 key cleared", v, 32'h5);
    rd(5'd21, v); chk(v == 0, "R4 shadow untouched", v, 0);
    // R3/R7/R8: direct read
    wr(5'd5, 32'h1); poll(nb, np);
    chk(nb == 9, "R7 read busy", nb, 9);
    chk(np == 2, "R8 read pulse", np, 2);
    rd(5'd6, v); chk(v == 32'hF0, "R3 result", v, 32'hF0);
    wr(5'd1, KEYW); wr(5'd4, 32'h0F00_0001); poll(nb, np);
    wr(5'd5, 32'h1); poll(nb, np);
    rd(5'd6, v); chk(v == 32'h0F00_00F1, "R4 or-merge", v, 32'h0F00_00F1);
    // R5: wrong key
    wr(5'd1, 32'h1234_0000); wr(5'd4, 32'hFFFF_FFFF);
    rd(5'd0, v); chk(v == 32'h0000_0205, "R5 err and key zero", v, 32'h205);
    wr(5'd5, 32'h1); poll(nb, np);
    rd(5'd6, v); chk(v == 32'h0F00_00F1, "R5 fuse unchanged", v, 32'h0F00_00F1);
    // R10: error clearing rules
    wr(5'd0, 32'h5); rd(5'd0, v); chk(v[9] == 1'b1, "R10 base keeps err", v, 32'h205);
    wr(5'd2, 32'h200); rd(5'd0, v); chk(v == 32'h5, "R10 clr alias", v, 32'h5);
    // R9: overlap interlock
    wr(5'd5, 32'h1); wr(5'd5, 32'h1); wr(5'd3, 32'h0);
    poll(nb, np);
    rd(5'd3, v); chk(v == T0, "R9 timing kept", v, T0);
    rd(5'd0, v); chk(v[9] == 1'b1, "R9 err set", v, 32'h205);
    wr(5'd2, 32'h200);
    // R6/R7: reload
    wr(5'd1, 32'h400); rd(5'd0, v); chk(v[10] == 1'b1, "R6 reload bit", v, 32'h505);
    poll(nb, np); chk(nb == 16 * 9 - 1, "R7 reload busy", nb, 16 * 9 - 1);
    rd(5'd0, v); chk(v[10] == 1'b0, "R6 reload self-clear", v, 32'h5);
    rd(5'd21, v); chk(v == 32'h0F00_00F1, "R6 shadow copy", v, 32'h0F00_00F1);
    rd(5'd16, v); chk(v == 0, "R6 shadow zero word", v, 0);
    // R8: no pulse when relax swallows the strobe
    wr(5'd3, T1); wr(5'd5, 32'h1); poll(nb, np);
    chk(np == 0, "R8 no pulse", np, 0);
    chk(nb == 9, "R7 read busy 2", nb, 9);
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule